// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block caches recent virtual-to-physical page translations so that a core can translate addresses without walking page tables. Each of its 64 slots holds a virtual page number, the identifier of the owning process, a physical frame number and four attribute flags: valid, global, dirty and non-cacheable. Every slot is compared against the requested page number in the same cycle. A slot qualifies only when it is valid, its page number is equal, and it either belongs to the current process or is marked global. Because slots carry a process tag, switching context only requires writing a new current-process value. No flush is needed.

A lookup reports one of three outcomes. A hit returns the frame and flags. A miss tells outside logic or software to refill the buffer. A modify fault is raised when a store reaches a qualifying slot whose dirty flag is clear. Refill goes through an install port. An install fills the lowest-numbered free slot. When no slot is free, it overwrites the slot named by a rotating pointer. Software keeps the buffer coherent with two commands. The first drops every slot for one virtual page. The second empties the whole buffer, which is used when process tagging is not relied upon.

Top module: `tagged_xlat_cache`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so any lookup misses (lk_miss=1, lk_pfn=0), and the current process value is 0.
- R2: While lk_req is high, a lookup is answered combinationally in the same cycle. A qualifying slot (valid, equal page number, and process tag equal to the current process or global flag set) drives lk_pfn, lk_nc, lk_dirty and lk_global from its stored fields.
- R3: While lk_req is high, exactly one of lk_hit, lk_miss and lk_mod_fault is 1. With no qualifying slot, lk_miss=1 and lk_pfn, lk_nc, lk_dirty and lk_global are all 0.
- R4: A store lookup (lk_store=1) that qualifies on a slot whose dirty flag is 0 gives lk_mod_fault=1 and lk_hit=0, and still presents the frame. A load to the same slot, or a store to a dirty slot, gives lk_hit=1.
- R5: A global slot qualifies under any current process. A non-global slot qualifies only under its own process. A write through ctx_pid_we changes the current process at the next clock edge.
- R6: An accepted install takes effect at the next clock edge and is placed in the lowest-numbered invalid slot when one exists. The installed slot is always valid.
- R7: With every slot valid, an accepted install overwrites the slot given by a rotating pointer. The pointer resets to 0 and advances by one, modulo the slot count, on every accepted install.
- R8: inv_en removes, at the next edge, every slot whose page number equals inv_vpn, whatever its process tag. Other slots are untouched.
- R9: flush_en makes every slot invalid at the next edge.
- R10: An install in the same cycle as inv_en or flush_en is dropped. It writes no slot and does not advance the rotating pointer.
- R11: While lk_req is low, lk_hit, lk_miss and lk_mod_fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctx_pid_we | input | 1 | Load the current process register |
| ctx_pid_wdata | input | 8 | New current process value |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_store | input | 1 | Lookup is for a store access |
| lk_hit | output | 1 | Translation found and usable |
| lk_miss | output | 1 | No qualifying slot |
| lk_mod_fault | output | 1 | Store reached a clean page |
| lk_pfn | output | 20 | Physical frame number of the qualifying slot |
| lk_nc | output | 1 | Non-cacheable flag of the qualifying slot |
| lk_dirty | output | 1 | Dirty flag of the qualifying slot |
| lk_global | output | 1 | Global flag of the qualifying slot |
| ins_en | input | 1 | Install request |
| ins_vpn | input | 20 | Page number to install |
| ins_pid | input | 8 | Process tag to install |
| ins_pfn | input | 20 | Frame number to install |
| ins_nc | input | 1 | Non-cacheable flag to install |
| ins_dirty | input | 1 | Dirty flag to install |
| ins_global | input | 1 | Global flag to install |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_en | input | 1 | Invalidate all slots |

## Verification
The property that at most one slot qualifies for a lookup holds only if software never installs a translation that overlaps a live one. Two translations overlap when they share a page number and their contexts intersect, meaning the same process tag or either one global. The stimulus meets this by giving every installed translation its own page number and by refilling only after invalidate or flush. The remaining properties assume that commands are held for whole cycles, with inputs changed only away from the rising edge, and the bench drives all of its stimulus on falling edges.

// File: rtl/xlat_pkg.sv
// Shared widths and the slot record for the tagged translation buffer.
// Assumes one fixed page-number, process-tag and frame width per build.
package xlat_pkg;
    localparam int VPN_W = 20;
    localparam int PID_W = 8;
    localparam int PFN_W = 20;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic             dirty;
        logic             nc;
        logic [PFN_W-1:0] pfn;
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
    } xlat_entry_t;
endpackage

// File: rtl/xlat_store.sv
// Slot storage. Applies flush, then per-page invalidate, then a single
// indexed write. Assumes the caller already dropped writes that collide
// with an invalidate or flush.
module xlat_store
    import xlat_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  xlat_entry_t        wr_data,
    input  logic               inv_en,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic               flush_en,
    output xlat_entry_t        entries [ENTRIES],
    output logic [ENTRIES-1:0] valid_vec
);
    // Update every slot according to the command priority.
    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                entries[i] <= '0;
            end else if (flush_en) begin
                entries[i].valid <= 1'b0;
            end else if (inv_en && entries[i].vpn == inv_vpn) begin
                entries[i].valid <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                entries[i] <= wr_data;
            end
        end
    end

    // Expose the valid flags as a flat vector.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = entries[g].valid;
    end
endmodule

// File: rtl/xlat_match.sv
// Parallel tag compare. A slot qualifies when it is valid, its page
// number is equal, and it is global or owned by the given process.
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  xlat_entry_t        entries [ENTRIES],
    input  logic [VPN_W-1:0]   vpn,
    input  logic [PID_W-1:0]   pid,
    output logic [ENTRIES-1:0] match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = entries[g].valid && (entries[g].vpn == vpn) &&
                          (entries[g].glob || entries[g].pid == pid);
    end
endmodule

// File: rtl/xlat_pick.sv
// Selects the qualifying slot's record. Assumes at most one match; the
// lowest index wins otherwise. Outputs zero when nothing matches.
module xlat_pick
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic [ENTRIES-1:0] match,
    input  xlat_entry_t        entries [ENTRIES],
    output logic               any,
    output xlat_entry_t        sel
);
    // Priority-select the matching record.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) sel = entries[i];
        end
        any = |match;
    end
endmodule

// File: rtl/xlat_victim.sv
// Install slot choice: the lowest invalid slot, otherwise the rotating
// pointer. The pointer steps once per accepted install.
module xlat_victim #(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   victim_idx
);
    logic [IDX_W-1:0] rr_ptr;

    // Rotating pointer, wrapping at the slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (advance) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    // Prefer the lowest free slot over the pointer.
    always_comb begin
        victim_idx = rr_ptr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tagged_xlat_cache.sv
// Top of the tagged translation buffer. It holds the current process
// register, gates installs against invalidate and flush, and forms the
// three lookup outcomes. Assumes software never installs an overlapping
// translation.
module tagged_xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctx_pid_we,
    input  logic [PID_W-1:0] ctx_pid_wdata,
    input  logic             lk_req,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             lk_store,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_mod_fault,
    output logic [PFN_W-1:0] lk_pfn,
    output logic             lk_nc,
    output logic             lk_dirty,
    output logic             lk_global,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PID_W-1:0] ins_pid,
    input  logic [PFN_W-1:0] ins_pfn,
    input  logic             ins_nc,
    input  logic             ins_dirty,
    input  logic             ins_global,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_en
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [PID_W-1:0]   ctx_pid;
    logic               ins_go;
    logic [IDX_W-1:0]   victim_idx;
    xlat_entry_t        wr_data;
    xlat_entry_t        entries [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] match_vec;
    logic               any_match;
    xlat_entry_t        sel;
    logic               found;

    // Current process register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_pid <= '0;
        end else if (ctx_pid_we) begin
            ctx_pid <= ctx_pid_wdata;
        end
    end

    // Invalidate or flush in the same cycle overrides an install.
    always_comb begin
        ins_go        = ins_en && !inv_en && !flush_en;
        wr_data       = '0;
        wr_data.valid = 1'b1;
        wr_data.glob  = ins_global;
        wr_data.dirty = ins_dirty;
        wr_data.nc    = ins_nc;
        wr_data.pfn   = ins_pfn;
        wr_data.pid   = ins_pid;
        wr_data.vpn   = ins_vpn;
    end

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_vec  (valid_vec),
        .advance    (ins_go),
        .victim_idx (victim_idx)
    );

    xlat_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ins_go),
        .wr_idx    (victim_idx),
        .wr_data   (wr_data),
        .inv_en    (inv_en),
        .inv_vpn   (inv_vpn),
        .flush_en  (flush_en),
        .entries   (entries),
        .valid_vec (valid_vec)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_match (
        .entries (entries),
        .vpn     (lk_vpn),
        .pid     (ctx_pid),
        .match   (match_vec)
    );

    xlat_pick #(.ENTRIES(ENTRIES)) u_pick (
        .match   (match_vec),
        .entries (entries),
        .any     (any_match),
        .sel     (sel)
    );

    // Classify the lookup and present the selected record.
    always_comb begin
        found        = lk_req && any_match;
        lk_miss      = lk_req && !any_match;
        lk_mod_fault = found && lk_store && !sel.dirty;
        lk_hit       = found && !(lk_store && !sel.dirty);
        lk_pfn       = found ? sel.pfn   : '0;
        lk_nc        = found ? sel.nc    : 1'b0;
        lk_dirty     = found ? sel.dirty : 1'b0;
        lk_global    = found ? sel.glob  : 1'b0;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
// Property checker for the tagged translation buffer, bound to the top.
// Assumes no overlapping translation is ever installed.
module xlat_cache_chk
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_req,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_mod_fault,
    input logic               ins_en,
    input logic               inv_en,
    input logic [VPN_W-1:0]   inv_vpn,
    input logic               flush_en,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] match_vec,
    input xlat_entry_t        entries [ENTRIES]
);
    logic [VPN_W-1:0]   last_inv_vpn;
    logic [ENTRIES-1:0] residue;

    // Remember the page named by the latest invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) last_inv_vpn <= '0;
        else if (inv_en) last_inv_vpn <= inv_vpn;
    end

    // Slots still live for the remembered page.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            residue[i] = entries[i].valid && entries[i].vpn == last_inv_vpn;
        end
    end

    // R2: at most one slot qualifies for a lookup
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> $countones({lk_hit, lk_miss, lk_mod_fault}) == 1);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_miss || lk_mod_fault));

    a_r6_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !inv_en && !flush_en && !(&valid_vec)) |=>
        $countones(valid_vec) == $past($countones(valid_vec)) + 1);

    a_r7_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !inv_en && !flush_en && (&valid_vec)) |=> (&valid_vec));

    a_r8_inv_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !flush_en) |=> residue == '0);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_en |=> valid_vec == '0);

    a_r10_cmd_blocks_install: assert property (@(posedge clk) disable iff (!rst_n)
        ((inv_en || flush_en) && ins_en) |=>
        $countones(valid_vec) <= $past($countones(valid_vec)));
endmodule

bind tagged_xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_req       (lk_req),
    .lk_hit       (lk_hit),
    .lk_miss      (lk_miss),
    .lk_mod_fault (lk_mod_fault),
    .ins_en       (ins_en),
    .inv_en       (inv_en),
    .inv_vpn      (inv_vpn),
    .flush_en     (flush_en),
    .valid_vec    (valid_vec),
    .match_vec    (match_vec),
    .entries      (entries)
);

// File: tb/tb_tagged_xlat_cache.sv
// Self-checking bench: a lookup vector table followed by directed tests.
module tb_tagged_xlat_cache;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctx_pid_we = 1'b0;
    logic [7:0]  ctx_pid_wdata = '0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_store = 1'b0;
    logic        lk_hit, lk_miss, lk_mod_fault;
    logic [19:0] lk_pfn;
    logic        lk_nc, lk_dirty, lk_global;
    logic        ins_en = 1'b0;
    logic [19:0] ins_vpn = '0;
    logic [7:0]  ins_pid = '0;
    logic [19:0] ins_pfn = '0;
    logic        ins_nc = 1'b0, ins_dirty = 1'b0, ins_global = 1'b0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_en = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int rr_model = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tagged_xlat_cache #(.ENTRIES(N)) dut (.*);

    typedef struct packed {
        logic [7:0]  pid;
        logic [19:0] vpn;
        logic        st;
        logic [2:0]  e_out;   // {hit, miss, mod_fault}
        logic [19:0] e_pfn;
        logic        e_nc;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd3, 20'h10, 1'b0, 3'b100, 20'hA000, 1'b0},   // R2 plain hit
        '{8'd3, 20'h10, 1'b1, 3'b100, 20'hA000, 1'b0},   // R4 store to dirty
        '{8'd3, 20'h20, 1'b0, 3'b100, 20'hB000, 1'b0},   // R4 load to clean
        '{8'd3, 20'h20, 1'b1, 3'b001, 20'hB000, 1'b0},   // R4 modify fault
        '{8'd3, 20'h30, 1'b0, 3'b010, 20'h0,    1'b0},   // R5 other process
        '{8'd9, 20'h30, 1'b0, 3'b100, 20'hC000, 1'b1},   // R5 own process, nc
        '{8'd9, 20'h40, 1'b0, 3'b100, 20'hD000, 1'b0},   // R5 global
        '{8'd3, 20'h40, 1'b0, 3'b100, 20'hD000, 1'b0},   // R5 global
        '{8'd9, 20'h10, 1'b0, 3'b010, 20'h0,    1'b0},   // R5 tag mismatch
        '{8'd3, 20'h50, 1'b0, 3'b010, 20'h0,    1'b0}    // R3 absent page
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic set_pid(input logic [7:0] p);
        @(negedge clk);
        ctx_pid_we = 1'b1; ctx_pid_wdata = p;
        @(negedge clk);
        ctx_pid_we = 1'b0;
    endtask

    task automatic install(input logic [19:0] v, input logic [7:0] p, input logic [19:0] f,
                           input logic nc, input logic d, input logic g);
        @(negedge clk);
        ins_en = 1'b1; ins_vpn = v; ins_pid = p; ins_pfn = f;
        ins_nc = nc; ins_dirty = d; ins_global = g;
        @(negedge clk);
        ins_en = 1'b0;
        rr_model = (rr_model + 1) % N;
    endtask

    task automatic look(input logic [19:0] v, input logic st);
        lk_req = 1'b1; lk_vpn = v; lk_store = st;
        #1;
    endtask

    // Expect the outcome triple for a load lookup of page v.
    task automatic expect_out(input string req, input logic [19:0] v, input logic [2:0] e);
        look(v, 1'b0);
        chk(req, {lk_hit, lk_miss, lk_mod_fault}, e);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: empty after reset, page 0 of process 0 must miss
        look(20'h0, 1'b0);
        chk("R1 reset miss", {lk_hit, lk_miss, lk_mod_fault}, 3'b010);
        chk("R1 reset pfn", lk_pfn, 20'h0);
        // R11: idle lookup is silent
        lk_req = 1'b0; #1;
        chk("R11 idle", {lk_hit, lk_miss, lk_mod_fault}, 3'b000);

        install(20'h10, 8'd3, 20'hA000, 1'b0, 1'b1, 1'b0);
        install(20'h20, 8'd3, 20'hB000, 1'b0, 1'b0, 1'b0);
        install(20'h30, 8'd9, 20'hC000, 1'b1, 1'b1, 1'b0);
        install(20'h40, 8'd5, 20'hD000, 1'b0, 1'b1, 1'b1);

        // R2 R3 R4 R5: table walk
        foreach (VECS[k]) begin
            set_pid(VECS[k].pid);
            look(VECS[k].vpn, VECS[k].st);
            chk($sformatf("R2-table vec %0d outcome", k), {lk_hit, lk_miss, lk_mod_fault}, VECS[k].e_out);
            chk($sformatf("R2-table vec %0d pfn", k), lk_pfn, VECS[k].e_pfn);
            chk($sformatf("R2-table vec %0d nc", k), lk_nc, VECS[k].e_nc);
        end
        // R2: global and dirty flags are reported
        set_pid(8'd3);
        look(20'h40, 1'b0);
        chk("R2 global flag", {lk_global, lk_dirty}, 2'b11);
        look(20'h20, 1'b0);
        chk("R2 clean flag", {lk_global, lk_dirty}, 2'b00);

        // R8: invalidate one page, others stay
        @(negedge clk);
        lk_req = 1'b0; inv_en = 1'b1; inv_vpn = 20'h20;
        @(negedge clk);
        inv_en = 1'b0;
        expect_out("R8 invalidated page", 20'h20, 3'b010);
        expect_out("R8 neighbour kept", 20'h10, 3'b100);

        // R10: install alongside an invalidate is dropped
        @(negedge clk);
        ins_en = 1'b1; ins_vpn = 20'h60; ins_pid = 8'd3; ins_pfn = 20'hE000;
        ins_dirty = 1'b1; ins_global = 1'b0; ins_nc = 1'b0;
        inv_en = 1'b1; inv_vpn = 20'h70;
        @(negedge clk);
        ins_en = 1'b0; inv_en = 1'b0;
        expect_out("R10 install dropped", 20'h60, 3'b010);

        // R9: flush empties everything, alongside an install
        @(negedge clk);
        flush_en = 1'b1;
        ins_en = 1'b1; ins_vpn = 20'h61;
        @(negedge clk);
        flush_en = 1'b0; ins_en = 1'b0;
        expect_out("R9 flushed page", 20'h10, 3'b010);
        expect_out("R9 flushed global", 20'h40, 3'b010);
        expect_out("R10 install under flush dropped", 20'h61, 3'b010);

        // R6: fill all slots in order
        set_pid(8'd1);
        for (int i = 0; i < N; i++) begin
            install(20'h100 + 20'(i), 8'd1, 20'h8000 + 20'(i), 1'b0, 1'b1, 1'b0);
        end
        expect_out("R6 first filled", 20'h100, 3'b100);
        look(20'h100 + 20'(N - 1), 1'b0);
        chk("R6 last filled pfn", lk_pfn, 20'h8000 + 20'(N - 1));

        // R6: a freed slot is reused ahead of the rotating pointer
        @(negedge clk);
        lk_req = 1'b0; inv_en = 1'b1; inv_vpn = 20'h10A;
        @(negedge clk);
        inv_en = 1'b0;
        install(20'h200, 8'd1, 20'h9000, 1'b0, 1'b1, 1'b0);
        expect_out("R6 freed slot refilled", 20'h200, 3'b100);
        expect_out("R6 pointer slot untouched", 20'h100 + 20'(rr_model - 1), 3'b100);

        // R7: full buffer evicts the pointer slot, then the next one
        begin
            automatic int v1 = rr_model;
            install(20'h201, 8'd1, 20'h9001, 1'b0, 1'b1, 1'b0);
            expect_out("R7 victim evicted", 20'h100 + 20'(v1), 3'b010);
            expect_out("R7 new entry present", 20'h201, 3'b100);
            expect_out("R7 next slot kept", 20'h100 + 20'(v1 + 1), 3'b100);
            install(20'h202, 8'd1, 20'h9002, 1'b0, 1'b1, 1'b0);
            expect_out("R7 pointer advanced", 20'h100 + 20'(v1 + 1), 3'b010);
            expect_out("R7 earlier install kept", 20'h201, 3'b100);
        end

        // R5: context value applies only after the write edge
        @(negedge clk);
        ctx_pid_we = 1'b1; ctx_pid_wdata = 8'd2;
        look(20'h200, 1'b0);
        chk("R5 before edge", {lk_hit, lk_miss, lk_mod_fault}, 3'b100);
        @(negedge clk);
        ctx_pid_we = 1'b0;
        expect_out("R5 after edge", 20'h200, 3'b010);

        // R11: idle again
        lk_req = 1'b0; #1;
        chk("R11 idle end", {lk_hit, lk_miss, lk_mod_fault}, 3'b000);

        finish_run();
    end
endmodule